// File: doc/BRIEF.md
# Rank-Counting Interest Point Sorter

This block collects one frame of interest points, each a column, a row and an interest value. When the frame closes, it writes the points into an output store in decreasing order of interest value. Points arrive one per cycle on a load strobe while the frame is being collected. A frame-end pulse hands the filled buffer to the sorter. From that moment the next frame's points go into a second buffer. The sort of one frame therefore overlaps the collection of the next.

The sorter does not swap points. It computes a rank for each point and uses that rank directly as the write address in the output store. A point's rank is the number of points with a strictly larger value, plus the number of points with an equal value that were loaded earlier. Every point therefore gets a distinct address, and equal values keep their load order. One comparison is made per cycle, so a frame of p points takes exactly p·p cycles.

The result is read through a combinational address port. A done flag marks when the whole frame has been placed, and a count gives the number of valid entries.

Top module: `rank_sort_engine`

## Requirements
- R1: After reset, done and busy are low, out_cnt is 0 and every output address reads zero column, row and value.
- R2: When done is high, output addresses 0 to out_cnt-1 hold exactly the points of the sorted frame, with values non-increasing as the address rises.
- R3: A point is placed at an address equal to the count of points with a strictly greater value plus the count of equal-valued points loaded before it. Equal values therefore appear in load order.
- R4: A frame_end accepted at clock edge 0 with p > 0 points raises done at edge p·p. At that same edge out_cnt shows p.
- R5: A frame_end accepted with no points collected raises done at the accepting edge itself. out_cnt reads 0 and the output store keeps its previous contents.
- R6: Points loaded while a sort runs go into the other buffer. They do not change the running sort's result, and they form the next frame.
- R7: A frame_end raised while busy is high is ignored. It does not change the running sort's timing and does not close the frame being collected.
- R8: A frame holds at most N_PTS points. Loads beyond that are dropped, and the first N_PTS points are kept.
- R9: An accepted frame_end with p > 0 clears done at the accepting edge. done stays low until the sort completes.
- R10: A load presented in the same cycle as an accepted frame_end becomes the first point of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid | input | 1 | Load strobe for one point |
| ld_x | input | X_W | Column of the loaded point |
| ld_y | input | Y_W | Row of the loaded point |
| ld_val | input | V_W | Interest value of the loaded point |
| frame_end | input | 1 | Closes the collected frame and starts its sort |
| busy | output | 1 | A sort is running |
| done | output | 1 | The last accepted frame is fully placed |
| out_cnt | output | $clog2(N_PTS+1) | Number of points in the last accepted frame |
| rd_addr | input | $clog2(N_PTS) | Output store read address |
| rd_x | output | X_W | Column at rd_addr |
| rd_y | output | Y_W | Row at rd_addr |
| rd_val | output | V_W | Interest value at rd_addr |

## Verification
Take the clock edge that accepts frame_end as edge 0. done is due at edge p·p, or at edge 0 for an empty frame. out_cnt is due at edge 0, and the collection counter and buffer select also change at edge 0. The bench drives every input at a falling edge and polls done at each later falling edge, so the first sample that shows done fixes the rising edge exactly. That index is compared with p·p. Stimulus for the overlapped frame is scheduled by the same falling-edge index, placing each load and the ignored frame_end at a known cycle of the running sort. The read port is combinational, so entries are read one time step after rd_addr changes, away from any clock edge.

// File: rtl/rank_sort_pkg.sv
// Package: shared types for the rank-counting sorter.
// Assumes: nothing beyond IEEE 1800-2017.
package rank_sort_pkg;

    typedef enum logic [0:0] {
        RS_IDLE = 1'b0,
        RS_RUN  = 1'b1
    } rank_state_e;

endpackage

// File: rtl/rank_collect_ctrl.sv
// Module: rank_collect_ctrl
// Tracks which of the two point buffers is collecting and how full it is.
// It accepts a frame close only when the sorter is idle.
// Assumes: the sorter reads the buffer named by closing_bank from the
// accepting edge until busy falls.
module rank_collect_ctrl #(
    parameter int N_PTS = 8,
    localparam int IW = (N_PTS > 1) ? $clog2(N_PTS) : 1,
    localparam int CW = $clog2(N_PTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_valid,
    input  logic          frame_end,
    input  logic          busy,
    output logic          accept,
    output logic          wr_en,
    output logic          wr_bank,
    output logic [IW-1:0] wr_idx,
    output logic          closing_bank,
    output logic [CW-1:0] closing_cnt
);

    localparam logic [CW-1:0] FULL = CW'(N_PTS);

    logic          col_sel;
    logic [CW-1:0] col_cnt;

    // Frame close is honoured only while no sort is running.
    always_comb begin
        accept       = frame_end & ~busy;
        wr_bank      = accept ? ~col_sel : col_sel;
        wr_idx       = accept ? '0 : col_cnt[IW-1:0];
        wr_en        = ld_valid & (accept | (col_cnt < FULL));
        closing_bank = col_sel;
        closing_cnt  = col_cnt;
    end

    // Buffer select and fill count of the collecting buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_sel <= 1'b0;
            col_cnt <= '0;
        end else if (accept) begin
            col_sel <= ~col_sel;
            col_cnt <= ld_valid ? CW'(1) : '0;
        end else if (wr_en) begin
            col_cnt <= col_cnt + CW'(1);
        end
    end

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_cnt <= FULL);

    // R8
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_cnt == FULL && ld_valid && !accept) |=> col_cnt == FULL);

    // R7
    busy_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && frame_end) |=> $stable(col_sel));

endmodule

// File: rtl/rank_point_bank.sv
// Module: rank_point_bank
// Two point buffers. One is written by the collector while the sorter
// reads the other. There are two read ports: a full point and a value-only port.
// Assumes: the value occupies the low VW bits of each packed point.
module rank_point_bank #(
    parameter int N_PTS = 8,
    parameter int PW    = 36,
    parameter int VW    = 16,
    localparam int IW = (N_PTS > 1) ? $clog2(N_PTS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_bank,
    input  logic [IW-1:0] wr_idx,
    input  logic [PW-1:0] wr_data,
    input  logic          rd_bank,
    input  logic [IW-1:0] rd_idx_a,
    input  logic [IW-1:0] rd_idx_b,
    output logic [PW-1:0] rd_a,
    output logic [VW-1:0] rd_b_val
);

    logic [PW-1:0] bank_a [2];
    logic [VW-1:0] bank_b [2];

    for (genvar b = 0; b < 2; b++) begin : gen_bank
        logic [PW-1:0] cells [N_PTS];

        // Storage for one buffer; written only when selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int k = 0; k < N_PTS; k++) cells[k] <= '0;
            end else if (wr_en && (wr_bank == 1'(b))) begin
                cells[wr_idx] <= wr_data;
            end
        end

        assign bank_a[b] = cells[rd_idx_a];
        assign bank_b[b] = cells[rd_idx_b][VW-1:0];
    end

    // Read steering toward the buffer being sorted.
    always_comb begin
        rd_a     = bank_a[rd_bank];
        rd_b_val = bank_b[rd_bank];
    end

endmodule

// File: rtl/rank_engine.sv
// Module: rank_engine
// Serial rank counter. For each point i it compares point j against i once
// per cycle, for every j. On the last j it writes i at the counted rank.
// Assumes: accept is only raised while busy is low.
module rank_engine
    import rank_sort_pkg::*;
#(
    parameter int N_PTS = 8,
    parameter int PW    = 36,
    parameter int VW    = 16,
    localparam int IW = (N_PTS > 1) ? $clog2(N_PTS) : 1,
    localparam int CW = $clog2(N_PTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          closing_bank,
    input  logic [CW-1:0] closing_cnt,
    input  logic [PW-1:0] pt_i,
    input  logic [VW-1:0] val_j,
    output logic          sel,
    output logic [IW-1:0] idx_i,
    output logic [IW-1:0] idx_j,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] out_cnt,
    output logic          wr_en,
    output logic [IW-1:0] wr_addr,
    output logic [PW-1:0] wr_data
);

    rank_state_e   state;
    logic [CW-1:0] cnt;
    logic [CW-1:0] rank;
    logic [CW-1:0] rank_nx;
    logic [VW-1:0] val_i;
    logic          beats;
    logic          last_j;
    logic          last_i;

    // One comparison: does point j rank ahead of point i.
    always_comb begin
        val_i   = pt_i[VW-1:0];
        beats   = (val_j > val_i) || ((val_j == val_i) && (idx_j < idx_i));
        rank_nx = rank + CW'(beats);
        last_j  = (CW'(idx_j) == cnt - CW'(1));
        last_i  = (CW'(idx_i) == cnt - CW'(1));
        busy    = (state == RS_RUN);
        wr_en   = busy && last_j;
        wr_addr = rank_nx[IW-1:0];
        wr_data = pt_i;
        out_cnt = cnt;
    end

    // Sequencer over the (i, j) comparison pairs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RS_IDLE;
            sel   <= 1'b0;
            cnt   <= '0;
            idx_i <= '0;
            idx_j <= '0;
            rank  <= '0;
            done  <= 1'b0;
        end else begin
            case (state)
                RS_IDLE: begin
                    if (accept) begin
                        sel   <= closing_bank;
                        cnt   <= closing_cnt;
                        idx_i <= '0;
                        idx_j <= '0;
                        rank  <= '0;
                        if (closing_cnt == '0) begin
                            done <= 1'b1;
                        end else begin
                            done  <= 1'b0;
                            state <= RS_RUN;
                        end
                    end
                end
                RS_RUN: begin
                    if (last_j) begin
                        idx_j <= '0;
                        rank  <= '0;
                        idx_i <= idx_i + IW'(1);
                        if (last_i) begin
                            state <= RS_IDLE;
                            done  <= 1'b1;
                        end
                    end else begin
                        idx_j <= idx_j + IW'(1);
                        rank  <= rank_nx;
                    end
                end
                default: state <= RS_IDLE;
            endcase
        end
    end

    // R3
    rank_le_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> rank <= CW'(idx_j));

    // R2
    wr_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> CW'(wr_addr) < cnt);

    // R4
    j_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> CW'(idx_j) < cnt);

    // R4
    done_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R9
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && closing_cnt != '0) |=> (busy && !done));

    // R5
    empty_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && closing_cnt == '0) |=> (done && !busy));

endmodule

// File: rtl/rank_out_mem.sv
// Module: rank_out_mem
// Output store addressed by rank, with a combinational read port.
// Assumes: at most one write per cycle.
module rank_out_mem #(
    parameter int N_PTS = 8,
    parameter int PW    = 36,
    localparam int IW = (N_PTS > 1) ? $clog2(N_PTS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_addr,
    input  logic [PW-1:0] wr_data,
    input  logic [IW-1:0] rd_addr,
    output logic [PW-1:0] rd_data
);

    logic [PW-1:0] cells [N_PTS];

    // Ranked entries; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N_PTS; k++) cells[k] <= '0;
        end else if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/rank_sort_engine.sv
// Module: rank_sort_engine (top)
// Collects a frame of points into a double buffer. On frame_end it sorts
// them by decreasing value into an output store, using rank counting.
// Assumes: points are packed as {x, y, value} with the value in the low bits.
module rank_sort_engine #(
    parameter int N_PTS = 8,
    parameter int X_W   = 10,
    parameter int Y_W   = 10,
    parameter int V_W   = 16,
    localparam int IW = (N_PTS > 1) ? $clog2(N_PTS) : 1,
    localparam int CW = $clog2(N_PTS + 1),
    localparam int PW = X_W + Y_W + V_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ld_valid,
    input  logic [X_W-1:0] ld_x,
    input  logic [Y_W-1:0] ld_y,
    input  logic [V_W-1:0] ld_val,
    input  logic           frame_end,
    output logic           busy,
    output logic           done,
    output logic [CW-1:0]  out_cnt,
    input  logic [IW-1:0]  rd_addr,
    output logic [X_W-1:0] rd_x,
    output logic [Y_W-1:0] rd_y,
    output logic [V_W-1:0] rd_val
);

    logic          accept;
    logic          bk_wr_en;
    logic          bk_wr_bank;
    logic [IW-1:0] bk_wr_idx;
    logic          closing_bank;
    logic [CW-1:0] closing_cnt;
    logic          sort_sel;
    logic [IW-1:0] idx_i;
    logic [IW-1:0] idx_j;
    logic [PW-1:0] pt_i;
    logic [V_W-1:0] val_j;
    logic          om_wr_en;
    logic [IW-1:0] om_wr_addr;
    logic [PW-1:0] om_wr_data;
    logic [PW-1:0] om_rd_data;

    rank_collect_ctrl #(.N_PTS(N_PTS)) u_collect (
        .clk          (clk),
        .rst_n        (rst_n),
        .ld_valid     (ld_valid),
        .frame_end    (frame_end),
        .busy         (busy),
        .accept       (accept),
        .wr_en        (bk_wr_en),
        .wr_bank      (bk_wr_bank),
        .wr_idx       (bk_wr_idx),
        .closing_bank (closing_bank),
        .closing_cnt  (closing_cnt)
    );

    rank_point_bank #(.N_PTS(N_PTS), .PW(PW), .VW(V_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bk_wr_en),
        .wr_bank  (bk_wr_bank),
        .wr_idx   (bk_wr_idx),
        .wr_data  ({ld_x, ld_y, ld_val}),
        .rd_bank  (sort_sel),
        .rd_idx_a (idx_i),
        .rd_idx_b (idx_j),
        .rd_a     (pt_i),
        .rd_b_val (val_j)
    );

    rank_engine #(.N_PTS(N_PTS), .PW(PW), .VW(V_W)) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept       (accept),
        .closing_bank (closing_bank),
        .closing_cnt  (closing_cnt),
        .pt_i         (pt_i),
        .val_j        (val_j),
        .sel          (sort_sel),
        .idx_i        (idx_i),
        .idx_j        (idx_j),
        .busy         (busy),
        .done         (done),
        .out_cnt      (out_cnt),
        .wr_en        (om_wr_en),
        .wr_addr      (om_wr_addr),
        .wr_data      (om_wr_data)
    );

    rank_out_mem #(.N_PTS(N_PTS), .PW(PW)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (om_wr_en),
        .wr_addr (om_wr_addr),
        .wr_data (om_wr_data),
        .rd_addr (rd_addr),
        .rd_data (om_rd_data)
    );

    // Unpack the ranked entry for the read port.
    always_comb begin
        rd_x   = om_rd_data[PW-1 -: X_W];
        rd_y   = om_rd_data[V_W +: Y_W];
        rd_val = om_rd_data[V_W-1:0];
    end

    // R6
    sort_bank_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bk_wr_en) |-> (bk_wr_bank != sort_sel));

endmodule

// File: tb/rank_sort_engine_tb.sv
module rank_sort_engine_tb;

    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic [9:0]  ld_x = '0;
    logic [9:0]  ld_y = '0;
    logic [15:0] ld_val = '0;
    logic        frame_end = 1'b0;
    logic        busy;
    logic        done;
    logic [3:0]  out_cnt;
    logic [2:0]  rd_addr = '0;
    logic [9:0]  rd_x;
    logic [9:0]  rd_y;
    logic [15:0] rd_val;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Model of the collecting frame and the frame under sort.
    int pn = 0;
    int px [N];
    int py [N];
    int pv [N];
    int sn = 0;
    int sx [N];
    int sy [N];
    int sv [N];
    int ln = 0;
    int lx [N];
    int ly [N];
    int lv [N];

    rank_sort_engine u_dut (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_x(ld_x), .ld_y(ld_y),
        .ld_val(ld_val), .frame_end(frame_end), .busy(busy), .done(done),
        .out_cnt(out_cnt), .rd_addr(rd_addr), .rd_x(rd_x), .rd_y(rd_y), .rd_val(rd_val)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Present one load in the current cycle and record it in the model.
    task automatic set_load(input int x, input int y, input int v);
        ld_valid = 1'b1;
        ld_x = 10'(x);
        ld_y = 10'(y);
        ld_val = 16'(v);
        if (pn < N) begin
            px[pn] = x; py[pn] = y; pv[pn] = v; pn++;
        end
    endtask

    task automatic load(input int x, input int y, input int v);
        @(negedge clk);
        set_load(x, y, v);
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic snapshot();
        sn = pn;
        for (int k = 0; k < N; k++) begin
            sx[k] = px[k]; sy[k] = py[k]; sv[k] = pv[k];
        end
        pn = 0;
    endtask

    // Expected order: stable descending by value, read back and compared.
    task automatic verify(input string tag);
        int ord [N];
        for (int k = 0; k < sn; k++) begin
            int pos = k;
            while (pos > 0 && sv[ord[pos-1]] < sv[k]) begin
                ord[pos] = ord[pos-1];
                pos--;
            end
            ord[pos] = k;
        end
        for (int a = 0; a < sn; a++) begin
            rd_addr = 3'(a);
            #1;
            chk(int'(rd_val) == sv[ord[a]], {tag, " value"}, int'(rd_val), sv[ord[a]]);
            chk(int'(rd_x) == sx[ord[a]], {tag, " column"}, int'(rd_x), sx[ord[a]]);
            chk(int'(rd_y) == sy[ord[a]], {tag, " row"}, int'(rd_y), sy[ord[a]]);
            lx[a] = sx[ord[a]]; ly[a] = sy[ord[a]]; lv[a] = sv[ord[a]];
        end
        if (sn > 0) ln = sn;
    endtask

    // Close the frame, time done against p*p, then check the order.
    task automatic run_frame(input string tag, input bit has_ld,
                             input int x, input int y, input int v);
        int k = -1;
        @(negedge clk);
        frame_end = 1'b1;
        snapshot();
        if (has_ld) set_load(x, y, v);
        for (int n = 0; n <= N * N + 4; n++) begin
            @(negedge clk);
            frame_end = 1'b0;
            ld_valid = 1'b0;
            if (done) begin k = n; break; end
        end
        chk(k == sn * sn, "R4 done edge after frame_end", k, sn * sn);
        chk(int'(out_cnt) == sn, "R4 out_cnt", int'(out_cnt), sn);
        verify(tag);
    endtask

    task automatic t_reset();
        chk(done == 1'b0, "R1 done at reset", int'(done), 0);
        chk(busy == 1'b0, "R1 busy at reset", int'(busy), 0);
        chk(out_cnt == 4'd0, "R1 out_cnt at reset", int'(out_cnt), 0);
        for (int a = 0; a < N; a++) begin
            rd_addr = 3'(a);
            #1;
            chk({rd_x, rd_y, rd_val} == '0, "R1 store cleared", int'(rd_val), 0);
        end
    endtask

    task automatic t_basic();
        load(1, 2, 30);
        load(3, 4, 200);
        load(5, 6, 7);
        load(7, 8, 150);
        load(9, 10, 90);
        run_frame("R2 distinct values", 1'b0, 0, 0, 0);
    endtask

    task automatic t_ties();
        load(11, 1, 50);
        load(12, 2, 80);
        load(13, 3, 50);
        load(14, 4, 50);
        run_frame("R3 equal values keep load order", 1'b0, 0, 0, 0);
    endtask

    task automatic t_empty();
        int cn = ln;
        int cx [N];
        int cy [N];
        int cv [N];
        for (int k = 0; k < N; k++) begin
            cx[k] = lx[k]; cy[k] = ly[k]; cv[k] = lv[k];
        end
        run_frame("R5 empty frame", 1'b0, 0, 0, 0);
        for (int a = 0; a < cn; a++) begin
            rd_addr = 3'(a);
            #1;
            chk(int'(rd_val) == cv[a] && int'(rd_x) == cx[a] && int'(rd_y) == cy[a],
                "R5 store kept after empty frame", int'(rd_val), cv[a]);
        end
    endtask

    task automatic t_overflow();
        for (int k = 0; k < N; k++) load(20 + k, 40 + k, (k * 37) % 11);
        load(99, 99, 999);
        load(98, 98, 998);
        run_frame("R8 excess loads dropped", 1'b0, 0, 0, 0);
    endtask

    task automatic t_overlap();
        int k = -1;
        load(1, 1, 10);
        load(2, 2, 40);
        load(3, 3, 20);
        load(4, 4, 40);
        @(negedge clk);
        frame_end = 1'b1;
        snapshot();
        for (int n = 0; n <= N * N + 4; n++) begin
            @(negedge clk);
            frame_end = 1'b0;
            ld_valid = 1'b0;
            if (done) begin k = n; break; end
            if (n == 0) set_load(30, 31, 500);
            if (n == 1) set_load(32, 33, 5);
            if (n == 2) frame_end = 1'b1;
            if (n == 3) set_load(34, 35, 60);
        end
        chk(k == 16, "R7 frame_end while busy leaves done edge", k, 16);
        chk(int'(out_cnt) == 4, "R6 running frame count", int'(out_cnt), 4);
        verify("R6 sort undisturbed by loads");
        run_frame("R6 overlapped loads form next frame", 1'b0, 0, 0, 0);
    endtask

    task automatic t_same_cycle();
        load(50, 51, 7);
        load(52, 53, 9);
        run_frame("R10 frame with concurrent load", 1'b1, 60, 61, 3);
        run_frame("R10 concurrent load starts next frame", 1'b0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R4 watchdog actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_ties();
        t_empty();
        t_overflow();
        t_overlap();
        t_same_cycle();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule